// File: doc/BRIEF.md
# DMA Command Enqueue Front End

This block sits between a host register port and a DMA transfer engine. The host programs four staging registers: a local-store address, the upper and lower halves of a 64-bit effective address, and a word that packs the transfer size with a tag. It then writes a command word. On that write the block decodes the opcode and checks the two address-validity flags supplied from outside. It either places the request in a small first-in first-out queue or refuses it. A result code replaces the command register in the next cycle, so the host polls one register to learn the outcome.

The transfer engine drains the queue through a valid/ready handshake and receives the oldest request with all of its fields. The block also answers a tag-status query. Writing the value 2 into the query-select register causes the block to copy the query-mask register into the query-status register and to clear the select register. Moving the data is outside this block.

Top module: `dma_cmd_enqueue`

## Requirements
- R1: The opcode is bits 15:0 of a nonzero command write. 0x0020 means PUT and 0x0040 means GET. Any other value is unknown. An unknown opcode leaves the queue unchanged and keeps the written word in the command register. It also raises `cmd_err` for exactly the cycle after the write.
- R2: A nonzero command write with a known opcode, both validity flags high, and room in the queue stores one entry. The command register then reads 0x00000000 in the next cycle.
- R3: If `ls_ok` or `ea_ok` is low during a known-opcode command write, the command register reads 0x00000001 and nothing is stored. This code wins over the queue-full code.
- R4: The queue holds at most DEPTH (default 8) entries. A valid known-opcode command write while DEPTH entries are held, with no pop in the same cycle, yields code 0x00000002 and stores nothing.
- R5: When the queue is full, a command write in the same cycle as a pop (`xfer_valid` and `xfer_ready` both high) is accepted with code 0x00000000. The queue remains at DEPTH entries.
- R6: Each entry carries the opcode, the tag from size/tag bits 15:0, the size from bits 31:16, the local-store address, and the effective address {EA-high, EA-low}, with EA-high in bits 63:32.
- R7: Entries leave in the order they were stored. An entry is taken on a cycle where `xfer_valid` and `xfer_ready` are both high. While `xfer_valid` is high and `xfer_ready` is low, the presented entry does not change.
- R8: A command write of zero stores zero, enqueues nothing and raises no error. A single strobe acts on the command once only.
- R9: While the query-select register holds 2, the next clock clears it to 0 and copies the query-mask register into the query-status register. Any other value stays and has no effect.
- R10: After reset, every register reads 0, `xfer_valid` is low and `cmd_err` is low.
- R11: The register addresses are 0 local-store address, 1 EA-high, 2 EA-low, 3 size/tag, 4 command/result, 5 query-status, 6 query-select and 7 query-mask. `reg_rdata` shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data |
| ls_ok | input | 1 | Local-store range is valid for the command being written |
| ea_ok | input | 1 | Effective-address range is valid for the command being written |
| cmd_err | output | 1 | One-cycle pulse after an unknown opcode |
| xfer_valid | output | 1 | Queue head is presented |
| xfer_ready | input | 1 | Transfer engine takes the head |
| xfer_op | output | 16 | Head opcode |
| xfer_tag | output | 16 | Head tag |
| xfer_lsa | output | 32 | Head local-store address |
| xfer_ea | output | 64 | Head effective address |
| xfer_size | output | 16 | Head transfer size |

## Verification
The bench fills the queue to exactly eight entries and then tries a ninth. A design with an off-by-one depth would either return the full code one entry early or store an entry past capacity, and the later drain would deliver an item the scoreboard never saw. A bad address is written while the queue is full: a design with the checks in the wrong order would report queue full instead of the sequence error. A command written in the same cycle as a pop must be accepted, and the next write must still report full. A design that ignores the pop would refuse that command, and one with wrong count arithmetic would accept the next one. The bench also covers unknown opcodes, a zero command, query values other than 2, and a drain under a stuttering ready. These catch a design that enqueues garbage, re-acts to a stale command, or drops or reorders entries.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  parameter int REG_W  = 32;
  parameter int HALF_W = REG_W / 2;
  parameter int EA_W   = 2 * REG_W;
  parameter int RA_W   = 3;

  parameter logic [HALF_W-1:0] OP_PUT = 16'h0020;
  parameter logic [HALF_W-1:0] OP_GET = 16'h0040;
  parameter logic [REG_W-1:0]  QUERY_TAG = 32'd2;

  typedef enum logic [REG_W-1:0] {
    RES_OK   = 32'd0,
    RES_SEQ  = 32'd1,
    RES_FULL = 32'd2
  } dmaq_res_e;

  typedef enum logic [RA_W-1:0] {
    RA_LSADDR = 3'd0,
    RA_EAHI   = 3'd1,
    RA_EALO   = 3'd2,
    RA_SZTAG  = 3'd3,
    RA_CMD    = 3'd4,
    RA_QSTAT  = 3'd5,
    RA_QSEL   = 3'd6,
    RA_QMASK  = 3'd7
  } dmaq_ra_e;

  typedef struct packed {
    logic [HALF_W-1:0] op;
    logic [HALF_W-1:0] tag;
    logic [REG_W-1:0]  lsa;
    logic [EA_W-1:0]   ea;
    logic [HALF_W-1:0] size;
  } dmaq_entry_t;
endpackage

// File: rtl/dmaq_regs.sv
module dmaq_regs
  import dmaq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [RA_W-1:0]  waddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [RA_W-1:0]  raddr,
  output logic [REG_W-1:0] rdata,
  input  logic             res_vld,
  input  logic [REG_W-1:0] res_code,
  output logic [REG_W-1:0] lsa_q,
  output logic [REG_W-1:0] eahi_q,
  output logic [REG_W-1:0] ealo_q,
  output logic [REG_W-1:0] sztag_q,
  output logic [REG_W-1:0] cmd_q
);
  logic [REG_W-1:0] lsa_d, eahi_d, ealo_d, sztag_d, cmd_d;
  logic [REG_W-1:0] qstat_q, qstat_d, qsel_q, qsel_d, qmask_q, qmask_d;

  always_comb begin
    lsa_d   = lsa_q;
    eahi_d  = eahi_q;
    ealo_d  = ealo_q;
    sztag_d = sztag_q;
    cmd_d   = cmd_q;
    qstat_d = qstat_q;
    qsel_d  = qsel_q;
    qmask_d = qmask_q;
    if (qsel_q == QUERY_TAG) begin
      qsel_d  = '0;
      qstat_d = qmask_q;
    end
    if (wr) begin
      case (waddr)
        RA_LSADDR: lsa_d   = wdata;
        RA_EAHI:   eahi_d  = wdata;
        RA_EALO:   ealo_d  = wdata;
        RA_SZTAG:  sztag_d = wdata;
        RA_CMD:    cmd_d   = res_vld ? res_code : wdata;
        RA_QSTAT:  qstat_d = wdata;
        RA_QSEL:   qsel_d  = wdata;
        default:   qmask_d = wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsa_q   <= '0;
      eahi_q  <= '0;
      ealo_q  <= '0;
      sztag_q <= '0;
      cmd_q   <= '0;
      qstat_q <= '0;
      qsel_q  <= '0;
      qmask_q <= '0;
    end else begin
      lsa_q   <= lsa_d;
      eahi_q  <= eahi_d;
      ealo_q  <= ealo_d;
      sztag_q <= sztag_d;
      cmd_q   <= cmd_d;
      qstat_q <= qstat_d;
      qsel_q  <= qsel_d;
      qmask_q <= qmask_d;
    end
  end

  always_comb begin
    case (raddr)
      RA_LSADDR: rdata = lsa_q;
      RA_EAHI:   rdata = eahi_q;
      RA_EALO:   rdata = ealo_q;
      RA_SZTAG:  rdata = sztag_q;
      RA_CMD:    rdata = cmd_q;
      RA_QSTAT:  rdata = qstat_q;
      RA_QSEL:   rdata = qsel_q;
      default:   rdata = qmask_q;
    endcase
  end

  // R9: a select value of 2 is consumed on the next clock
  p_query_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (qsel_q == QUERY_TAG && !(wr && waddr == RA_QSEL)) |=> qsel_q == '0);

  // R9: the mask lands in the status register
  p_query_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (qsel_q == QUERY_TAG && !(wr && waddr == RA_QSTAT)) |=> qstat_q == $past(qmask_q));
endmodule

// File: rtl/dmaq_cmd_ctl.sv
module dmaq_cmd_ctl
  import dmaq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [REG_W-1:0] cmd_word,
  input  logic             ls_ok,
  input  logic             ea_ok,
  input  logic             full,
  input  logic             pop,
  input  logic [REG_W-1:0] lsa_q,
  input  logic [REG_W-1:0] eahi_q,
  input  logic [REG_W-1:0] ealo_q,
  input  logic [REG_W-1:0] sztag_q,
  output logic             push,
  output logic             res_vld,
  output logic [REG_W-1:0] res_code,
  output dmaq_entry_t      entry,
  output logic             cmd_err
);
  logic [HALF_W-1:0] op;
  logic              known, active, err_d;

  always_comb begin
    op       = cmd_word[HALF_W-1:0];
    known    = (op == OP_PUT) || (op == OP_GET);
    active   = cmd_wr && (cmd_word != '0);
    res_vld  = active && known;
    push     = 1'b0;
    res_code = RES_OK;
    if (!(ls_ok && ea_ok)) begin
      res_code = RES_SEQ;
    end else if (full && !pop) begin
      res_code = RES_FULL;
    end else begin
      push = res_vld;
    end
    err_d = active && !known;
  end

  always_comb begin
    entry.op   = op;
    entry.tag  = sztag_q[HALF_W-1:0];
    entry.size = sztag_q[REG_W-1:HALF_W];
    entry.lsa  = lsa_q;
    entry.ea   = {eahi_q, ealo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= err_d;
  end
endmodule

// File: rtl/dmaq_fifo.sv
module dmaq_fifo
  import dmaq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  dmaq_entry_t push_data,
  input  logic        ready,
  output logic        valid,
  output logic        full,
  output logic        pop,
  output dmaq_entry_t head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  dmaq_entry_t      mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    valid = (cnt_q != '0);
    full  = (cnt_q == CNT_W'(DEPTH));
    pop   = valid && ready;
    head  = mem_q[rptr_q];
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (pop)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wptr_q] <= push_data;
  end

  // R4: occupancy never exceeds the depth
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R4: a store into a full queue needs a pop
  p_full_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);

  // R5: a pop together with a store keeps the queue full
  p_stay_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && full) |=> full);

  // R7: the head holds while stalled
  p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(head)));
endmodule

// File: rtl/dma_cmd_enqueue.sv
module dma_cmd_enqueue
  import dmaq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_waddr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [RA_W-1:0]   reg_raddr,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ls_ok,
  input  logic              ea_ok,
  output logic              cmd_err,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [HALF_W-1:0] xfer_op,
  output logic [HALF_W-1:0] xfer_tag,
  output logic [REG_W-1:0]  xfer_lsa,
  output logic [EA_W-1:0]   xfer_ea,
  output logic [HALF_W-1:0] xfer_size
);
  logic             cmd_wr, push, res_vld, full, pop;
  logic [REG_W-1:0] res_code, lsa_q, eahi_q, ealo_q, sztag_q, cmd_q;
  dmaq_entry_t      entry, head;

  assign cmd_wr = reg_wr && (reg_waddr == RA_CMD);

  dmaq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .res_vld(res_vld), .res_code(res_code),
    .lsa_q(lsa_q), .eahi_q(eahi_q), .ealo_q(ealo_q), .sztag_q(sztag_q), .cmd_q(cmd_q)
  );

  dmaq_cmd_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(reg_wdata),
    .ls_ok(ls_ok), .ea_ok(ea_ok), .full(full), .pop(pop),
    .lsa_q(lsa_q), .eahi_q(eahi_q), .ealo_q(ealo_q), .sztag_q(sztag_q),
    .push(push), .res_vld(res_vld), .res_code(res_code), .entry(entry), .cmd_err(cmd_err)
  );

  dmaq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(entry), .ready(xfer_ready),
    .valid(xfer_valid), .full(full), .pop(pop), .head(head)
  );

  assign xfer_op   = head.op;
  assign xfer_tag  = head.tag;
  assign xfer_lsa  = head.lsa;
  assign xfer_ea   = head.ea;
  assign xfer_size = head.size;

  // R1: an error pulse leaves an unrecognised opcode in the command register
  p_err_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (cmd_q[HALF_W-1:0] != OP_PUT && cmd_q[HALF_W-1:0] != OP_GET && cmd_q != '0));

  // R3: an invalid range reports the sequence code
  p_seq_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (reg_wdata[HALF_W-1:0] == OP_PUT || reg_wdata[HALF_W-1:0] == OP_GET)
     && !(ls_ok && ea_ok)) |=> (cmd_q == REG_W'(1) && !cmd_err));

  // R4: a full queue with no pop reports the full code
  p_full_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (reg_wdata[HALF_W-1:0] == OP_PUT || reg_wdata[HALF_W-1:0] == OP_GET)
     && ls_ok && ea_ok && full && !xfer_ready) |=> cmd_q == REG_W'(2));
endmodule

// File: tb/dma_cmd_enqueue_test.sv
module dma_cmd_enqueue_test;
  logic        clk, rst_n, reg_wr, ls_ok, ea_ok, xfer_ready;
  logic [2:0]  reg_waddr, reg_raddr;
  logic [31:0] reg_wdata, reg_rdata, xfer_lsa;
  logic        cmd_err, xfer_valid;
  logic [15:0] xfer_op, xfer_tag, xfer_size;
  logic [63:0] xfer_ea;

  typedef struct {
    logic [15:0] op;
    logic [15:0] tag;
    logic [31:0] lsa;
    logic [63:0] ea;
    logic [15:0] size;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic [31:0] s_lsa, s_eah, s_eal;
  logic [15:0] s_size, s_tag;

  dma_cmd_enqueue uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .ls_ok(ls_ok), .ea_ok(ea_ok),
    .cmd_err(cmd_err), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_op(xfer_op),
    .xfer_tag(xfer_tag), .xfer_lsa(xfer_lsa), .xfer_ea(xfer_ea), .xfer_size(xfer_size)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_raddr = a;
    #1;
    check(req, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic prog(input logic [31:0] lsa, input logic [31:0] eah, input logic [31:0] eal,
                      input logic [15:0] size, input logic [15:0] tag);
    wr(3'd0, lsa); wr(3'd1, eah); wr(3'd2, eal); wr(3'd3, {size, tag});
    s_lsa = lsa; s_eah = eah; s_eal = eal; s_size = size; s_tag = tag;
  endtask

  // issue a command; exp is the expected command register, a push is modelled when expected
  task automatic issue(input string req, input logic [31:0] word, input logic [31:0] exp,
                       input logic exp_err, input logic stores);
    if (stores) sb.push_back('{word[15:0], s_tag, s_lsa, {s_eah, s_eal}, s_size});
    wr(3'd4, word);
    rdchk(req, 3'd4, exp);
    check({req, " err"}, {63'd0, cmd_err}, {63'd0, exp_err});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && xfer_valid && xfer_ready) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R7: actual unexpected entry tag %h expected none", xfer_tag);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check("R7 order/op", {48'd0, xfer_op}, {48'd0, e.op});
        check("R6 tag", {48'd0, xfer_tag}, {48'd0, e.tag});
        check("R6 size", {48'd0, xfer_size}, {48'd0, e.size});
        check("R6 lsa", {32'd0, xfer_lsa}, {32'd0, e.lsa});
        check("R6 ea", xfer_ea, e.ea);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
    ls_ok = 1'b1; ea_ok = 1'b1; xfer_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int a = 0; a < 8; a++) rdchk("R10 reg", 3'(a), 32'd0);
    check("R10 valid", {63'd0, xfer_valid}, 64'd0);
    check("R10 err", {63'd0, cmd_err}, 64'd0);

    // R11 / R6 staging and readback
    prog(32'h0000_1000, 32'hDEAD_0001, 32'h0000_2000, 16'h0080, 16'h0005);
    rdchk("R11 lsa", 3'd0, 32'h0000_1000);
    rdchk("R11 eah", 3'd1, 32'hDEAD_0001);
    rdchk("R11 eal", 3'd2, 32'h0000_2000);
    rdchk("R11 sztag", 3'd3, 32'h0080_0005);

    // R2 PUT accepted
    issue("R2 put", 32'h0000_0020, 32'd0, 1'b0, 1'b1);
    check("R2 valid", {63'd0, xfer_valid}, 64'd1);

    // R1 unknown opcodes, including upper bits set with a known-looking pattern
    issue("R1 unknown", 32'h0000_0030, 32'h0000_0030, 1'b1, 1'b0);
    @(negedge clk); #1;
    check("R1 pulse ends", {63'd0, cmd_err}, 64'd0);
    issue("R1 low zero", 32'h0020_0000, 32'h0020_0000, 1'b1, 1'b0);

    // R3 sequence error on a bad local-store range
    ls_ok = 1'b0;
    issue("R3 ls bad", 32'h0000_0040, 32'd1, 1'b0, 1'b0);
    ls_ok = 1'b1;

    // fill to eight with GETs of distinct tags
    for (int i = 0; i < 7; i++) begin
      prog(32'h100 * i, 32'h0000_00A0 + i, 32'hF000_0000 | i, 16'(16 + i), 16'(32'h40 + i));
      issue("R2 get", 32'h0000_0040, 32'd0, 1'b0, 1'b1);
    end

    // R4 full
    issue("R4 full", 32'h0000_0020, 32'd2, 1'b0, 1'b0);
    // R3 priority over full
    ea_ok = 1'b0;
    issue("R3 prio over full", 32'h0000_0040, 32'd1, 1'b0, 1'b0);
    ea_ok = 1'b1;

    // R5 simultaneous pop and store while full
    prog(32'h0000_7777, 32'h1234_5678, 32'h9ABC_DEF0, 16'h0200, 16'h00EE);
    xfer_ready = 1'b1;
    issue("R5 push with pop", 32'h0000_0020, 32'd0, 1'b0, 1'b1);
    xfer_ready = 1'b0;
    issue("R5 still full", 32'h0000_0040, 32'd2, 1'b0, 1'b0);

    // R7 drain with stuttering ready
    for (int i = 0; i < 30; i++) begin
      xfer_ready = (i % 3) != 2;
      @(negedge clk);
    end
    xfer_ready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R7 drained", {63'd0, xfer_valid}, 64'd0);
    check("R7 scoreboard empty", 64'(sb.size()), 64'd0);

    // R8 zero command does nothing, single strobe acts once
    issue("R8 zero", 32'd0, 32'd0, 1'b0, 1'b0);
    repeat (2) @(negedge clk); #1;
    check("R8 no entry", {63'd0, xfer_valid}, 64'd0);
    prog(32'h0000_0ABC, 32'h0, 32'h0000_0444, 16'h0010, 16'h0077);
    issue("R8 once", 32'h0000_0040, 32'd0, 1'b0, 1'b1);
    repeat (4) @(negedge clk); #1;
    check("R8 single entry", {63'd0, xfer_valid}, 64'd0);

    // R9 query
    wr(3'd7, 32'h0000_A5A5);
    wr(3'd6, 32'd1);
    @(negedge clk);
    rdchk("R9 other value stays", 3'd6, 32'd1);
    rdchk("R9 no copy", 3'd5, 32'd0);
    wr(3'd6, 32'd2);
    rdchk("R9 select held", 3'd6, 32'd2);
    @(negedge clk);
    rdchk("R9 select cleared", 3'd6, 32'd0);
    rdchk("R9 status copied", 3'd5, 32'h0000_A5A5);

    repeat (2) @(negedge clk);
    check("R7 no stray items", 64'(sb.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule